// File: doc/BRIEF.md
# Dilation-Sized Circular State Queue

This block caches the recurrent activation vectors of one layer in an autoregressive dilated convolution network. It holds `DEPTH` vectors, where `DEPTH` is the layer's dilation. Each vector has `CHANNELS` signed fixed-point elements that are 27 bits wide (8 integer bits, 19 fraction bits). One generation time step does two things. The consumer first reads the oldest vector out one element at a time, and that vector feeds the convolution. The producer then writes the freshly computed vector, element by element, into the same slot.

Nothing is ever shifted. A single slot pointer selects the oldest vector. When the last element of a push is written, the pointer moves forward by one and wraps to zero after `DEPTH-1`. A synchronous clear, like reset, makes the whole history read as zero. It does this with one written-flag per slot, so no storage word is rewritten. A write port gate enforces the order inside a step: a push is accepted only after the read of the final channel has been issued.

Top module: `state_ring_queue`

## Requirements
- R1: After reset or `clear`, every element read returns 0, `empty` is 1, `wr_ready` is 0, and the slot pointer is at slot 0.
- R2: `rd_valid` is 1 in exactly the cycle after a cycle with `rd_req` high, and `rd_data` holds the addressed element in that cycle.
- R3: A read returns element `rd_ch` of the slot under the pointer, which is the vector whose push completed `DEPTH` steps earlier, or 0 if that slot has not been filled since the last clear.
- R4: `wr_ready` rises in the cycle after a read of channel `CHANNELS-1` is issued. A `wr_en` while `wr_ready` is 0 leaves the stored data, the pointer and `empty` unchanged.
- R5: An accepted write with `wr_last` high completes the push. The slot is marked filled, the pointer advances modulo `DEPTH`, and `wr_ready` is 0 in the following cycle.
- R6: With `DEPTH` = 1 the pointer stays at slot 0, so every step reads back the vector pushed in the previous step.
- R7: `clear` takes priority. A read requested in the same cycle returns 0, and a write in that cycle is discarded.
- R8: `empty` goes to 0 in the cycle after the first completed push following reset or clear, and returns to 1 after a clear.
- R9: Elements are stored bit-exact as signed 27-bit values, including the most negative (-2^26) and most positive (2^26-1) codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous clear of the whole history |
| rd_req | input | 1 | Read request for one element of the oldest vector |
| rd_ch | input | CH_W | Element (channel) index of the read |
| rd_data | output | ELEM_W | Read element, signed fixed point |
| rd_valid | output | 1 | `rd_data` valid, one cycle after `rd_req` |
| wr_en | input | 1 | Write one element of the new vector |
| wr_ch | input | CH_W | Element (channel) index of the write |
| wr_data | input | ELEM_W | Element to store |
| wr_last | input | 1 | Marks the final element of the push |
| wr_ready | output | 1 | Pop of the current step is done, so writes are accepted |
| empty | output | 1 | No vector pushed since reset or clear |

## Verification
The bench builds two copies of the block with three channels each, one with `DEPTH` = 4 and one with `DEPTH` = 1, and drives both with the same stimulus. The depth-4 copy lets the pointer wrap several times. It also exposes the four-step delay between a push and its read-back, and shows zero history for the first steps after reset and after a mid-run clear. The depth-1 copy covers the degenerate ring in which the pointer never moves and each pop returns the vector of the step before. Both copies also get writes issued before the pop ends, a clear that coincides with a read and a write, and the two signed extreme values.

// File: rtl/state_ring_queue.sv
module state_ring_queue #(
  parameter int DEPTH    = 8,
  parameter int CHANNELS = 4,
  parameter int ELEM_W   = 27,
  localparam int CH_W    = (CHANNELS > 1) ? $clog2(CHANNELS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear,
  input  logic                     rd_req,
  input  logic [CH_W-1:0]          rd_ch,
  output logic signed [ELEM_W-1:0] rd_data,
  output logic                     rd_valid,
  input  logic                     wr_en,
  input  logic [CH_W-1:0]          wr_ch,
  input  logic signed [ELEM_W-1:0] wr_data,
  input  logic                     wr_last,
  output logic                     wr_ready,
  output logic                     empty
);
  localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int ENTRIES = DEPTH * CHANNELS;
  localparam int AW      = (ENTRIES > 1) ? $clog2(ENTRIES) + 1 : 1;

  logic signed [ELEM_W-1:0] mem [ENTRIES];
  logic [DEPTH-1:0]         filled;
  logic [PTR_W-1:0]         ptr;
  logic                     pop_done;

  logic             rd_ok, wr_ok, wr_go, commit, last_rd;
  logic [PTR_W-1:0] ptr_nxt;
  logic [AW-1:0]    rd_addr, wr_addr;

  assign rd_ok   = int'(rd_ch) < CHANNELS;
  assign wr_ok   = int'(wr_ch) < CHANNELS;
  assign rd_addr = AW'(ptr) * AW'(CHANNELS) + AW'(rd_ch);
  assign wr_addr = AW'(ptr) * AW'(CHANNELS) + AW'(wr_ch);
  assign wr_go   = wr_en && pop_done && !clear && wr_ok;
  assign commit  = wr_go && wr_last;
  assign last_rd = rd_req && (rd_ch == CH_W'(CHANNELS - 1));
  assign ptr_nxt = (ptr == PTR_W'(DEPTH - 1)) ? '0 : ptr + 1'b1;
  assign wr_ready = pop_done;
  assign empty    = ~|filled;

  always_ff @(posedge clk) begin
    if (wr_go) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr      <= '0;
      filled   <= '0;
      pop_done <= 1'b0;
    end else if (clear) begin
      ptr      <= '0;
      filled   <= '0;
      pop_done <= 1'b0;
    end else if (commit) begin
      filled[ptr] <= 1'b1;
      ptr         <= ptr_nxt;
      pop_done    <= 1'b0;
    end else if (last_rd) begin
      pop_done <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req)
        rd_data <= (clear || !rd_ok || !filled[ptr]) ? '0 : mem[rd_addr];
    end
  end

  assert_clear_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (empty && !wr_ready && ptr == '0));

  assert_zero_history_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && empty) |=> (rd_valid && rd_data == '0));

  assert_no_early_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_ready && !clear) |=> ($stable(ptr) && $stable(filled)));

  assert_push_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (!wr_ready && !empty));

  assert_ptr_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= PTR_W'(DEPTH - 1));

  assert_clear_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && clear) |=> (rd_data == '0));
endmodule

// File: tb/state_ring_queue_tb_top.sv
module state_ring_queue_tb_top;
  localparam int C = 3;
  localparam int W = 27;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear = 1'b0, rd_req = 1'b0, wr_en = 1'b0, wr_last = 1'b0;
  logic [1:0] rd_ch = '0, wr_ch = '0;
  logic signed [W-1:0] wr_data = '0;
  logic signed [W-1:0] rd_d [2];
  logic rd_v [2], wr_r [2], emp [2];

  always #10 clk = ~clk;

  state_ring_queue #(.DEPTH(4), .CHANNELS(C), .ELEM_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .clear(clear), .rd_req(rd_req), .rd_ch(rd_ch),
    .rd_data(rd_d[0]), .rd_valid(rd_v[0]), .wr_en(wr_en), .wr_ch(wr_ch),
    .wr_data(wr_data), .wr_last(wr_last), .wr_ready(wr_r[0]), .empty(emp[0]));

  state_ring_queue #(.DEPTH(1), .CHANNELS(C), .ELEM_W(W)) dut_d1 (
    .clk(clk), .rst_n(rst_n), .clear(clear), .rd_req(rd_req), .rd_ch(rd_ch),
    .rd_data(rd_d[1]), .rd_valid(rd_v[1]), .wr_en(wr_en), .wr_ch(wr_ch),
    .wr_data(wr_data), .wr_last(wr_last), .wr_ready(wr_r[1]), .empty(emp[1]));

  int total = 0, bad = 0, cycles = 0;
  string tag = "R1";

  // behavioural model: per lane, a ring of vectors with history flags
  int depth [2] = '{4, 1};
  logic signed [W-1:0] hist [2][4][C];
  bit  have [2][4];
  int  oldest [2];
  bit  popped [2];
  bit  ev [2];
  logic signed [W-1:0] ed [2];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic bit none_filled(input int k);
    for (int s = 0; s < 4; s++) if (have[k][s]) return 1'b0;
    return 1'b1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    for (int k = 0; k < 2; k++) begin
      if (!rst_n) begin
        for (int s = 0; s < 4; s++) have[k][s] = 1'b0;
        oldest[k] = 0; popped[k] = 1'b0; ev[k] = 1'b0; ed[k] = '0;
      end else begin
        ev[k] = rd_req;
        if (rd_req)
          ed[k] = (clear || !have[k][oldest[k]]) ? '0 : hist[k][oldest[k]][rd_ch];
        if (clear) begin
          for (int s = 0; s < 4; s++) have[k][s] = 1'b0;
          oldest[k] = 0; popped[k] = 1'b0;
        end else if (wr_en && popped[k]) begin
          hist[k][oldest[k]][wr_ch] = wr_data;
          if (wr_last) begin
            have[k][oldest[k]] = 1'b1;
            oldest[k] = (oldest[k] + 1) % depth[k];
            popped[k] = 1'b0;
          end
        end else if (rd_req && rd_ch == 2'(C - 1)) begin
          popped[k] = 1'b1;
        end
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    for (int k = 0; k < 2; k++) begin
      chk(rd_v[k] === ev[k], "R2", longint'(rd_v[k]), longint'(ev[k]));
      if (ev[k]) chk(rd_d[k] === ed[k], (k == 1) ? "R6" : tag, longint'(rd_d[k]), longint'(ed[k]));
      chk(wr_r[k] === popped[k], "R4", longint'(wr_r[k]), longint'(popped[k]));
      chk(emp[k] === none_filled(k), "R8", longint'(emp[k]), longint'(none_filled(k)));
    end
    if (cycles > 20000) begin
      chk(1'b0, "watchdog", cycles, 20000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic signed [W-1:0] val(input int base, input int ch);
    return W'(base * 7919 - ch * 131071 + 5);
  endfunction

  task automatic pop_all();
    for (int ch = 0; ch < C; ch++) begin
      rd_req = 1'b1; rd_ch = 2'(ch);
      @(negedge clk);
    end
    rd_req = 1'b0;
  endtask

  task automatic push_vec(input logic signed [W-1:0] v0, v1, v2);
    for (int ch = 0; ch < C; ch++) begin
      wr_en = 1'b1; wr_ch = 2'(ch); wr_last = (ch == C - 1);
      wr_data = (ch == 0) ? v0 : (ch == 1) ? v1 : v2;
      @(negedge clk);
    end
    wr_en = 1'b0; wr_last = 1'b0;
    chk(wr_r[0] === 1'b0 && wr_r[1] === 1'b0, "R5", longint'(wr_r[0]), 0);
  endtask

  task automatic step(input int base);
    pop_all();
    push_vec(val(base, 0), val(base, 1), val(base, 2));
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(emp[0] === 1'b1 && wr_r[0] === 1'b0, "R1", longint'(emp[0]), 1);
    tag = "R4";
    wr_en = 1'b1; wr_ch = '0; wr_data = 27'sd12345; wr_last = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_last = 1'b0;
    tag = "R1";
    step(1);
    tag = "R3";
    for (int t = 2; t <= 10; t++) step(t);
    tag = "R9";
    pop_all();
    push_vec(-27'sd67108864, 27'sd67108863, -27'sd1);
    for (int t = 0; t < 4; t++) step(20 + t);
    tag = "R4";
    pop_all();
    for (int ch = 0; ch < 2; ch++) begin
      wr_en = 1'b1; wr_ch = 2'(ch); wr_data = val(40, ch); wr_last = 1'b0;
      @(negedge clk);
    end
    wr_en = 1'b0;
    tag = "R7";
    rd_req = 1'b1; rd_ch = 2'd0; clear = 1'b1;
    wr_en = 1'b1; wr_ch = 2'd2; wr_data = 27'sd999; wr_last = 1'b1;
    @(negedge clk);
    clear = 1'b0; rd_req = 1'b0; wr_en = 1'b0; wr_last = 1'b0;
    @(negedge clk);
    chk(emp[0] === 1'b1 && emp[1] === 1'b1, "R7", longint'(emp[0]), 1);
    tag = "R1";
    step(50);
    tag = "R3";
    for (int t = 51; t <= 60; t++) step(t);
    pop_all();
    @(negedge clk); @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule